// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block derives a processor system clock and a slower peripheral clock from one of two fast source clocks. A select input picks either the oscillator source or an external frequency source. The chosen source is divided by three, giving a system clock that is high for one source period and low for two. The system clock is then halved to form a peripheral clock with an even duty cycle. The oscillator source is also passed straight through to an output so other logic can use it.

A sync input lets several generators run in step. While it is high, the divider is held at its start count. It resumes counting on the first source edge after the input falls, so generators released together stay in phase. An active-low reset request is passed through a two-stage synchroniser that advances on rising edges of the system clock. The synchroniser drives an active-high processor reset.

Everything is modelled as enable-based logic on one fast reference clock `clk_i`. The source clocks are sampled as data on this clock, and a source period is taken as the time between two sampled rising edges.

Top module: `cpu_clkgen`

## Requirements
- R1: While `rst_ni` is low, `sys_clk_o` reads 1, `pclk_o` reads 0 and `rst_o` reads 1.
- R2: With `src_sel_i` = 0, the oscillator input `osc_i` is the source. One system clock period spans three `osc_i` periods.
- R3: With `src_sel_i` = 1, the external input `ext_i` is the source. One system clock period spans three `ext_i` periods.
- R4: In every system clock period, `sys_clk_o` is high for exactly one source period and low for exactly two. `sys_clk_o` changes only in the cycle after a sampled source rising edge.
- R5: `pclk_o` toggles only in the cycle in which `sys_clk_o` falls. It is therefore high for one system period and low for one, at half the system frequency.
- R6: `osc_o` always equals `osc_i`, whatever the value of `src_sel_i`.
- R7: While `sync_i` is high, the divider is held at its start count, so `sys_clk_o` stays 1 and `pclk_o` does not change. After `sync_i` falls, `sys_clk_o` falls on the first source edge. It is then low for two source periods and high for one.
- R8: `rst_o` is the inverse of `rst_req_ni` after two stages that each advance on a rising edge of `sys_clk_o`. A change of `rst_req_ni` reaches `rst_o` after the second such rising edge, never sooner, and `rst_o` changes only when `sys_clk_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock that samples everything |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| osc_i | input | 1 | Oscillator source clock, sampled as data |
| ext_i | input | 1 | External frequency source clock, sampled as data |
| src_sel_i | input | 1 | Source select: 0 oscillator, 1 external |
| sync_i | input | 1 | Holds the divider at its start count while high |
| rst_req_ni | input | 1 | Active-low reset request |
| osc_o | output | 1 | Oscillator input passed through |
| sys_clk_o | output | 1 | Divide-by-three system clock, one-third high |
| pclk_o | output | 1 | Peripheral clock at half the system clock |
| rst_o | output | 1 | Synchronised active-high processor reset |

## Verification
The divider is driven by two sources with different periods: 4 reference cycles for the oscillator and 6 for the external input. The measured high and low run lengths therefore show which source was selected, and they also show whether the one-third duty cycle holds for each source. The peripheral clock is measured over whole runs, and each of its changes is compared against a falling edge of the system clock. This catches a toggle on the wrong edge or a wrong division. Holding and then releasing sync shows whether the counter restarts from its start count rather than from where it stopped. Reset request latency is bounded from both sides, which separates a single-stage path from the two-stage one.

// File: rtl/cpu_clkgen_pkg.sv
package cpu_clkgen_pkg;
  typedef enum logic {
    SRC_OSC = 1'b0,
    SRC_EXT = 1'b1
  } src_sel_e;

  localparam int unsigned DIV_N_DEF      = 3;
  localparam int unsigned RST_STAGES_DEF = 2;
endpackage

// File: rtl/clkgen_src_pick.sv
module clkgen_src_pick
  import cpu_clkgen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  input  logic ext_i,
  input  logic sel_i,
  output logic src_edge_o
);
  logic osc_q, ext_q, prev_q, src_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q  <= 1'b0;
      ext_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      osc_q  <= osc_i;
      ext_q  <= ext_i;
      prev_q <= src_now;
    end
  end

  assign src_now    = (src_sel_e'(sel_i) == SRC_EXT) ? ext_q : osc_q;
  assign src_edge_o = src_now & ~prev_q;
endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider #(
  parameter int unsigned DIV_N = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_edge_i,
  input  logic sync_i,
  output logic sys_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (DIV_N > 2) ? $clog2(DIV_N) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);

  logic [CW-1:0] cnt_q;
  logic          adv, at_last, at_zero;

  assign adv     = src_edge_i & ~sync_i;
  assign at_last = (cnt_q == LAST);
  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (src_edge_i) begin
      if (sync_i)         cnt_q <= '0;
      else if (at_last)   cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  // high only in the start count: one source period of DIV_N
  assign sys_o  = at_zero;
  assign rise_o = adv & at_last;
  assign fall_o = adv & at_zero;
endmodule

// File: rtl/clkgen_half.sv
module clkgen_half (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  output logic pclk_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= 1'b0;
    else if (fall_i) q <= ~q;
  end

  assign pclk_o = q;
endmodule

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_ni,
  output logic rst_o
);
  logic [STAGES-1:0] q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic d;
    if (s == 0) begin : g_first
      assign d = req_ni;
    end else begin : g_next
      assign d = q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q[s] <= 1'b0;
      else if (en_i) q[s] <= d;
    end
  end

  assign rst_o = ~q[STAGES-1];
endmodule

// File: rtl/cpu_clkgen.sv
module cpu_clkgen
  import cpu_clkgen_pkg::*;
#(
  parameter int unsigned DIV_N      = DIV_N_DEF,
  parameter int unsigned RST_STAGES = RST_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  input  logic ext_i,
  input  logic src_sel_i,
  input  logic sync_i,
  input  logic rst_req_ni,
  output logic osc_o,
  output logic sys_clk_o,
  output logic pclk_o,
  output logic rst_o
);
  logic src_edge, sys_rise, sys_fall;

  clkgen_src_pick u_pick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_i      (osc_i),
    .ext_i      (ext_i),
    .sel_i      (src_sel_i),
    .src_edge_o (src_edge)
  );

  clkgen_divider #(.DIV_N(DIV_N)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_edge_i (src_edge),
    .sync_i     (sync_i),
    .sys_o      (sys_clk_o),
    .rise_o     (sys_rise),
    .fall_o     (sys_fall)
  );

  clkgen_half u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (sys_fall),
    .pclk_o (pclk_o)
  );

  clkgen_rst_sync #(.STAGES(RST_STAGES)) u_rsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sys_rise),
    .req_ni (rst_req_ni),
    .rst_o  (rst_o)
  );

  assign osc_o = osc_i;
endmodule

// File: rtl/cpu_clkgen_checker.sv
module cpu_clkgen_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_i,
  input logic src_edge_i,
  input logic sys_clk_i,
  input logic pclk_i,
  input logic rst_i
);
  assert_sys_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sys_clk_i) |-> $past(src_edge_i));

  assert_pclk_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pclk_i) |-> $fell(sys_clk_i));

  assert_sync_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_edge_i && sync_i) |=> sys_clk_i);

  assert_sync_no_pclk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> $stable(pclk_i));

  assert_rst_on_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rst_i) |-> $rose(sys_clk_i));
endmodule

bind cpu_clkgen cpu_clkgen_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_i     (sync_i),
  .src_edge_i (src_edge),
  .sys_clk_i  (sys_clk_o),
  .pclk_i     (pclk_o),
  .rst_i      (rst_o)
);

// File: tb/cpu_clkgen_test.sv
`timescale 1ns/1ps
module cpu_clkgen_test;
  localparam int OSC_HALF = 2;  // osc period 4 reference cycles
  localparam int EXT_HALF = 3;  // ext period 6 reference cycles

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_i = 1'b0, ext_i = 1'b0;
  logic src_sel_i = 1'b0, sync_i = 1'b0, rst_req_ni = 1'b1;
  logic osc_o, sys_clk_o, pclk_o, rst_o;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // sources change on negative edges only
  initial forever begin
    repeat (OSC_HALF) @(negedge clk);
    osc_i = ~osc_i;
  end
  initial forever begin
    repeat (EXT_HALF) @(negedge clk);
    ext_i = ~ext_i;
  end

  cpu_clkgen uut (
    .clk_i(clk), .rst_ni(rst_ni), .osc_i(osc_i), .ext_i(ext_i),
    .src_sel_i(src_sel_i), .sync_i(sync_i), .rst_req_ni(rst_req_ni),
    .osc_o(osc_o), .sys_clk_o(sys_clk_o), .pclk_o(pclk_o), .rst_o(rst_o)
  );

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sys_runs(output int hi, output int lo);
    do @(negedge clk); while (sys_clk_o != 1'b0);
    do @(negedge clk); while (sys_clk_o != 1'b1);
    hi = 0; lo = 0;
    while (sys_clk_o == 1'b1) begin hi++; @(negedge clk); end
    while (sys_clk_o == 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic pclk_runs(output int hi, output int lo, output int bad);
    logic ps, pp;
    bad = 0;
    do @(negedge clk); while (pclk_o != 1'b0);
    do @(negedge clk); while (pclk_o != 1'b1);
    hi = 0; lo = 0;
    ps = sys_clk_o; pp = pclk_o;
    while (pclk_o == 1'b1) begin
      hi++; @(negedge clk);
      if (pclk_o != pp && !(ps && !sys_clk_o)) bad++;
      ps = sys_clk_o; pp = pclk_o;
    end
    while (pclk_o == 1'b0) begin
      lo++; @(negedge clk);
      if (pclk_o != pp && !(ps && !sys_clk_o)) bad++;
      ps = sys_clk_o; pp = pclk_o;
    end
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check("R1 sys_clk in reset", sys_clk_o, 1);
    check("R1 pclk in reset", pclk_o, 0);
    check("R1 rst_o in reset", rst_o, 1);
    @(negedge clk) rst_ni = 1'b1;
  endtask

  task automatic t_divide(bit sel, int src_per, string tag);
    int hi, lo, ph, pl, bad;
    @(negedge clk) src_sel_i = sel;
    repeat (6 * src_per) @(negedge clk);
    sys_runs(hi, lo);
    check({tag, " R4 sys high run"}, hi, src_per);
    check({tag, " R4 sys low run"}, lo, 2 * src_per);
    pclk_runs(ph, pl, bad);
    check({tag, " R5 pclk high run"}, ph, 3 * src_per);
    check({tag, " R5 pclk low run"}, pl, 3 * src_per);
    check({tag, " R5 pclk change off sys fall"}, bad, 0);
  endtask

  task automatic t_passthru();
    int bad = 0;
    for (int s = 0; s < 2; s++) begin
      @(negedge clk) src_sel_i = s[0];
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (osc_o !== osc_i) bad++;
      end
    end
    check("R6 osc_o follows osc_i", bad, 0);
  endtask

  task automatic t_sync();
    int low_seen = 0, pchg = 0, wait_n = 0, lo = 0, hi = 0;
    logic p0;
    @(negedge clk) begin src_sel_i = 1'b0; sync_i = 1'b1; end
    repeat (8) @(negedge clk);
    p0 = pclk_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sys_clk_o) low_seen++;
      if (pclk_o != p0) pchg++;
    end
    check("R7 sys held high under sync", low_seen, 0);
    check("R7 pclk frozen under sync", pchg, 0);
    sync_i = 1'b0;
    while (sys_clk_o == 1'b1) begin wait_n++; @(negedge clk); end
    check("R7 fall within one source period", int'(wait_n <= 2 * OSC_HALF + 3), 1);
    while (sys_clk_o == 1'b0) begin lo++; @(negedge clk); end
    while (sys_clk_o == 1'b1) begin hi++; @(negedge clk); end
    check("R7 low run after release", lo, 4 * OSC_HALF);
    check("R7 high run after release", hi, 2 * OSC_HALF);
  endtask

  task automatic t_rst_req();
    int lat;
    int per = 6 * OSC_HALF;
    @(negedge clk) src_sel_i = 1'b0;
    repeat (2 * per) @(negedge clk);
    check("R8 rst_o released after startup", rst_o, 0);
    rst_req_ni = 1'b0; lat = 0;
    while (rst_o == 1'b0 && lat < 4 * per) begin @(negedge clk); lat++; end
    check("R8 assert latency lower bound", int'(lat >= per + 1), 1);
    check("R8 assert latency upper bound", int'(lat <= 2 * per + 2), 1);
    rst_req_ni = 1'b1; lat = 0;
    while (rst_o == 1'b1 && lat < 4 * per) begin @(negedge clk); lat++; end
    check("R8 release latency lower bound", int'(lat >= per + 1), 1);
    check("R8 release latency upper bound", int'(lat <= 2 * per + 2), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_divide(1'b0, 2 * OSC_HALF, "R2 osc");
    t_divide(1'b1, 2 * EXT_HALF, "R3 ext");
    t_passthru();
    t_sync();
    t_rst_req();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule